// File: doc/BRIEF.md
# Host Mailbox Latch Interface

This block sits between a host on a 16-bit bus and user logic inside the FPGA. It holds one word in each direction. A host data write loads the inbound latch with the 16 data bits. The same write also captures the three address bits of the access that sit above bit 0. User logic can take that word back as plain 16-bit data, or as a 19-bit word with the three address bits on top. In the other direction, user logic loads a 16-bit outbound latch, and the host reads it from the data offset.

The host can work in either of two ways. It can poll a status register at a separate offset, which shows one full flag for each latch. Or it can go straight to the data offset and be held by the `hostReady` line until the latch can take or give the word. User logic uses a request/acknowledge handshake. Each access takes at least two cycles. If a new access starts in the cycle right after an acknowledge, one idle turnaround cycle is added before it.

Top module: `host_mailbox`

## Requirements
- R1: A host write at the data offset (`hostStatusSel`=0) completes on a clock edge where `hostReady` is high. That edge stores `hostWData` and `hostAddr` in the inbound latch and sets the inbound full flag.
- R2: User operation codes are 0 for a 16-bit read, 1 for a 19-bit read and 2 for a 16-bit write; code 3 behaves as a 16-bit read.
  - A 16-bit read returns the stored data on `usrRData[15:0]`, with bits 18:16 at zero.
  - A 19-bit read returns the stored address bits on `usrRData[18:16]`, above the data.
  - Either read clears the inbound full flag.
- R3: A user write loads `usrWData` into the outbound latch and sets the outbound full flag. A host read at the data offset returns that word on `hostRData`, never any captured address bits, and clears the outbound full flag. This also holds for a word already in the latch when the read arrives.
- R4: A host read at the status offset (`hostStatusSel`=1) returns the inbound full flag in bit 0, the outbound full flag in bit 1, and zero in all other bits.
  - A status access changes no state.
  - A host write at the status offset is ignored.
- R5: A user access whose request is seen in a cycle not straight after an acknowledge, with its latch ready, is acknowledged in the next cycle. That is two cycles in all. `usrAck` lasts one cycle, and read data is valid while it is high.
- R6: A request present in the cycle straight after an acknowledge gets one idle cycle first, so it is acknowledged in the third cycle. Two acknowledges are never less than three cycles apart.
- R7: A user read waits with `usrAck` low while the inbound latch is empty. A user write waits while the outbound latch is full. Each completes in the cycle after the latch becomes ready, and no word is lost or overwritten.
- R8: `hostReady` is low only during a data-offset write while the inbound latch is full, or a data-offset read while the outbound latch is empty. It is high for status accesses and when no access is made.
- R9: After reset both full flags are clear, `usrAck` is low and `hostReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write access in progress |
| hostRdEn | input | 1 | Host read access in progress |
| hostStatusSel | input | 1 | 1 selects the status offset, 0 the data offset |
| hostAddr | input | 3 | Host address bits 1 to 3 of the access |
| hostWData | input | 16 | Host write data |
| hostRData | output | 16 | Host read data (outbound word or status) |
| hostReady | output | 1 | Low holds the host in a wait state |
| usrReq | input | 1 | User access request, held until acknowledged |
| usrOp | input | 2 | User operation code |
| usrWData | input | 16 | User write data |
| usrRData | output | 19 | User read data |
| usrAck | output | 1 | One-cycle acknowledge of a completed user access |

## Verification
The bench drives inputs on the falling edge and samples outputs one time step later, before the next rising edge. Host-side results are combinational and are read in that same cycle. For a user access, the bench counts cycles from the cycle in which it raises `usrReq` to the cycle in which `usrAck` is high. The expected count is two after an idle gap and three straight after an acknowledge. When the access has to wait for a latch, the expected count is worked out from the cycle in which the host side completes its transfer. Flag changes from a transfer are checked through the status register in the cycle after the transfer edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [1:0] OP_RD16 = 2'd0;
  localparam logic [1:0] OP_RD19 = 2'd1;
  localparam logic [1:0] OP_WR16 = 2'd2;

  typedef struct packed {
    logic inLoad;
    logic inTake;
    logic outLoad;
    logic outTake;
    logic wideRead;
  } mbx_strb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_XFER = 2'd2
  } usr_state_e;

endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  input  logic       hostStatusSel,
  input  logic       inFull,
  input  logic       outFull,
  input  logic       usrReq,
  input  logic [1:0] usrOp,
  output logic       usrAck,
  output logic       hostReady,
  output mbx_strb_t  strb
);

  usr_state_e state, stateNext;
  logic justDone;
  logic opIsWrite;
  logic latchOk;
  logic hostDataWr;
  logic hostDataRd;

  // Host side: a write takes priority over a read if both are raised.
  assign hostDataWr = hostWrEn && !hostStatusSel;
  assign hostDataRd = hostRdEn && !hostWrEn && !hostStatusSel;

  always_comb begin
    hostReady = 1'b1;
    if (hostDataWr)      hostReady = !inFull;
    else if (hostDataRd) hostReady = outFull;
  end

  // User side
  assign opIsWrite = (usrOp == OP_WR16);
  assign latchOk   = opIsWrite ? !outFull : inFull;
  assign usrAck    = (state == ST_XFER) && latchOk;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (usrReq) stateNext = justDone ? ST_GAP : ST_XFER;
      ST_GAP:  stateNext = ST_XFER;
      ST_XFER: if (latchOk) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      justDone <= 1'b0;
    end else begin
      state    <= stateNext;
      justDone <= usrAck;
    end
  end

  always_comb begin
    strb.inLoad   = hostDataWr && !inFull;
    strb.outTake  = hostDataRd && outFull;
    strb.inTake   = usrAck && !opIsWrite;
    strb.outLoad  = usrAck && opIsWrite;
    strb.wideRead = (usrOp == OP_RD19);
  end

  // R6: acknowledges are at least three cycles apart
  assert_ack_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    usrAck |=> !usrAck ##1 !usrAck);

  // R8: wait states only for data-offset accesses
  assert_ready_data_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hostReady |-> ((hostWrEn || hostRdEn) && !hostStatusSel));

  // R5: an acknowledge always answers a request seen in an earlier cycle
  assert_ack_after_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    usrAck |-> $past(usrReq));

endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int WIDE_W = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbx_strb_t         strb,
  input  logic              hostStatusSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWData,
  input  logic [DATA_W-1:0] usrWData,
  output logic [DATA_W-1:0] hostRData,
  output logic [WIDE_W-1:0] usrRData,
  output logic              inFull,
  output logic              outFull
);

  logic [DATA_W-1:0] inData;
  logic [ADDR_W-1:0] inAddr;
  logic [DATA_W-1:0] outData;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inData  <= '0;
      inAddr  <= '0;
      inFull  <= 1'b0;
    end else begin
      if (strb.inLoad) begin
        inData <= hostWData;
        inAddr <= hostAddr;
      end
      if (strb.inLoad)      inFull <= 1'b1;
      else if (strb.inTake) inFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      outFull <= 1'b0;
    end else begin
      if (strb.outLoad) outData <= usrWData;
      if (strb.outLoad)       outFull <= 1'b1;
      else if (strb.outTake)  outFull <= 1'b0;
    end
  end

  always_comb begin
    statusWord    = '0;
    statusWord[0] = inFull;
    statusWord[1] = outFull;
  end

  assign hostRData = hostStatusSel ? statusWord : outData;

  assign usrRData[DATA_W-1:0] = inData;
  for (genvar g = 0; g < ADDR_W; g++) begin : g_wide
    assign usrRData[DATA_W+g] = strb.wideRead & inAddr[g];
  end

  // R1: the host never loads over an unread word
  assert_no_overwrite_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.inLoad |-> !inFull);

  // R7: a full inbound latch stays full until the user takes it
  assert_in_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inFull && !strb.inTake) |=> inFull);

  // R3: the host only takes an outbound word that is there
  assert_out_take_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.outTake |-> outFull);

  // R7: the user never loads over an unread outbound word
  assert_out_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.outLoad |-> !outFull);

endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int WIDE_W = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic              hostStatusSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWData,
  output logic [DATA_W-1:0] hostRData,
  output logic              hostReady,
  input  logic              usrReq,
  input  logic [1:0]        usrOp,
  input  logic [DATA_W-1:0] usrWData,
  output logic [WIDE_W-1:0] usrRData,
  output logic              usrAck
);

  mbx_strb_t strb;
  logic inFull;
  logic outFull;

  mbx_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostWrEn     (hostWrEn),
    .hostRdEn     (hostRdEn),
    .hostStatusSel(hostStatusSel),
    .inFull       (inFull),
    .outFull      (outFull),
    .usrReq       (usrReq),
    .usrOp        (usrOp),
    .usrAck       (usrAck),
    .hostReady    (hostReady),
    .strb         (strb)
  );

  mbx_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .hostStatusSel(hostStatusSel),
    .hostAddr     (hostAddr),
    .hostWData    (hostWData),
    .usrWData     (usrWData),
    .hostRData    (hostRData),
    .usrRData     (usrRData),
    .inFull       (inFull),
    .outFull      (outFull)
  );

endmodule

// File: tb/host_mailbox_tb.sv
module host_mailbox_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic        hostStatusSel = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [15:0] hostWData = '0;
  logic [15:0] hostRData;
  logic        hostReady;
  logic        usrReq = 1'b0;
  logic [1:0]  usrOp = '0;
  logic [15:0] usrWData = '0;
  logic [18:0] usrRData;
  logic        usrAck;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_mailbox u_dut (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostStatusSel(hostStatusSel),
    .hostAddr(hostAddr), .hostWData(hostWData), .hostRData(hostRData),
    .hostReady(hostReady),
    .usrReq(usrReq), .usrOp(usrOp), .usrWData(usrWData),
    .usrRData(usrRData), .usrAck(usrAck)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [2:0] a, input logic [15:0] d,
                           output int waits);
    waits = 0;
    @(negedge clk);
    hostWrEn = 1'b1; hostStatusSel = sel; hostAddr = a; hostWData = d;
    #1;
    while (!hostReady) begin @(negedge clk); #1; waits++; end
    @(posedge clk); #1;
    hostWrEn = 1'b0; hostStatusSel = 1'b0;
  endtask

  task automatic hostRead(output logic [15:0] d, output int waits);
    waits = 0;
    @(negedge clk);
    hostRdEn = 1'b1; hostStatusSel = 1'b0;
    #1;
    while (!hostReady) begin @(negedge clk); #1; waits++; end
    d = hostRData;
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  // status read inside one cycle, between edges
  task automatic hostStatus(output logic [15:0] s, output logic rdy);
    @(negedge clk);
    hostRdEn = 1'b1; hostStatusSel = 1'b1;
    #1; s = hostRData; rdy = hostReady;
    #1; hostRdEn = 1'b0; hostStatusSel = 1'b0;
  endtask

  task automatic userOp(input logic [1:0] op, input logic [15:0] wd, input logic keep,
                        output logic [18:0] rd, output int cycles);
    cycles = 1;
    @(negedge clk);
    usrReq = 1'b1; usrOp = op; usrWData = wd;
    #1;
    while (!usrAck) begin @(negedge clk); #1; cycles++; end
    rd = usrRData;
    @(posedge clk); #1;
    if (!keep) usrReq = 1'b0;
  endtask

  task automatic idleCycle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] s, d, pat;
    logic [18:0] rd;
    logic rdy;
    int w, cyc;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    #1;
    chk("R9 ack", {31'd0, usrAck}, 32'd0);
    chk("R9 ready", {31'd0, hostReady}, 32'd1);
    hostStatus(s, rdy);
    chk("R9 status", {16'd0, s}, 32'd0);

    // R1 R2 R5: sweep over all address values and both read widths
    for (int a = 0; a < 8; a++) begin
      for (int k = 0; k < 2; k++) begin
        pat = 16'(a * 16'h2345 + k * 16'h1111) ^ 16'hA5A5;
        hostWrite(1'b0, 3'(a), pat, w);
        chk("R1 write no wait", w, 0);
        hostStatus(s, rdy);
        chk("R1 in flag set", {16'd0, s}, 32'h1);
        chk("R8 status ready", {31'd0, rdy}, 32'd1);
        idleCycle();
        userOp(k[1:0], 16'h0, 1'b0, rd, cyc);
        if (k == 1) chk("R2 wide read", {13'd0, rd}, {13'd0, 3'(a), pat});
        else        chk("R2 narrow read", {13'd0, rd}, {16'd0, pat});
        chk("R5 two cycles", cyc, 2);
        hostStatus(s, rdy);
        chk("R2 in flag clear", {16'd0, s}, 32'h0);
      end
    end

    // R2: reserved code 3 acts as narrow read
    hostWrite(1'b0, 3'd7, 16'hBEEF, w);
    idleCycle();
    userOp(2'd3, 16'h0, 1'b0, rd, cyc);
    chk("R2 code3 narrow", {13'd0, rd}, 32'h0000BEEF);

    // R3: user write then host read, several patterns
    for (int i = 0; i < 6; i++) begin
      pat = 16'(i * 16'h3C3C) ^ 16'h0F0F;
      idleCycle();
      userOp(2'd2, pat, 1'b0, rd, cyc);
      chk("R5 write two cycles", cyc, 2);
      hostStatus(s, rdy);
      chk("R3 out flag set", {16'd0, s}, 32'h2);
      hostRead(d, w);
      chk("R3 host read data", {16'd0, d}, {16'd0, pat});
      chk("R8 read no wait", w, 0);
      hostStatus(s, rdy);
      chk("R3 out flag clear", {16'd0, s}, 32'h0);
    end

    // R4: write at status offset ignored
    hostWrite(1'b1, 3'd5, 16'hFFFF, w);
    hostStatus(s, rdy);
    chk("R4 status write ignored", {16'd0, s}, 32'h0);

    // R6: back-to-back user accesses take 3 cycles, after a gap 2
    hostWrite(1'b0, 3'd2, 16'h1234, w);
    idleCycle();
    userOp(2'd2, 16'h5678, 1'b1, rd, cyc);
    chk("R5 first access", cyc, 2);
    userOp(2'd1, 16'h0, 1'b0, rd, cyc);
    chk("R6 back-to-back three cycles", cyc, 3);
    chk("R6 data", {13'd0, rd}, {13'd0, 3'd2, 16'h1234});
    hostRead(d, w);
    chk("R3 back-to-back word", {16'd0, d}, 32'h5678);

    // R8 R7: host read waits on empty outbound latch
    idleCycle();
    fork
      hostRead(d, w);
      begin repeat (2) @(negedge clk); userOp(2'd2, 16'hC0DE, 1'b0, rd, cyc); end
    join
    chk("R8 host read waits", w, 4);
    chk("R7 stalled host read data", {16'd0, d}, 32'hC0DE);

    // R8: host write waits while inbound full; R7 user read waits while empty
    hostWrite(1'b0, 3'd1, 16'hAAAA, w);
    fork
      hostWrite(1'b0, 3'd6, 16'h5555, w);
      begin repeat (3) @(negedge clk); userOp(2'd0, 16'h0, 1'b0, rd, cyc); end
    join
    chk("R8 host write waited", {31'd0, (w > 0)}, 32'd1);
    chk("R7 first word kept", {13'd0, rd}, 32'hAAAA);
    idleCycle();
    userOp(2'd1, 16'h0, 1'b0, rd, cyc);
    chk("R7 second word", {13'd0, rd}, {13'd0, 3'd6, 16'h5555});

    idleCycle();
    fork
      userOp(2'd1, 16'h0, 1'b0, rd, cyc);
      begin repeat (4) @(negedge clk); hostWrite(1'b0, 3'd3, 16'h7E57, w); end
    join
    chk("R7 user read stall cycles", cyc, 6);
    chk("R7 user read stall data", {13'd0, rd}, {13'd0, 3'd3, 16'h7E57});

    // R7: user write waits while outbound full
    idleCycle();
    userOp(2'd2, 16'h1111, 1'b0, rd, cyc);
    idleCycle();
    fork
      userOp(2'd2, 16'h2222, 1'b0, rd, cyc);
      begin repeat (3) @(negedge clk); hostRead(d, w); end
    join
    chk("R7 user write stall cycles", cyc, 5);
    chk("R3 stale word first", {16'd0, d}, 32'h1111);
    hostRead(d, w);
    chk("R7 second outbound word", {16'd0, d}, 32'h2222);
    hostStatus(s, rdy);
    chk("R4 final status", {16'd0, s}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule